// File: doc/BRIEF.md
# Serial ADC Frame Controller

This block is the host side of a link to a 16-clock serial analog-to-digital converter. From the system clock it makes an active-low chip-select and a divided serial clock, shifts in the converter's data line, and passes the captured word out with a one-cycle strobe. A command input picks one of three frames. A conversion frame clocks 16 bits. A sleep frame raises chip-select early, which puts the converter into its low-power state. A wake frame is a full-length frame whose data is thrown away.

The controller keeps its own record of whether the converter is asleep. After reset it assumes the converter is asleep, because its real state is unknown. A conversion request made while the converter is believed asleep is preceded automatically by a wake frame, and only the conversion that follows the wake frame produces a valid sample. Between any two frames, chip-select stays high for a programmable quiet time. The busy flag covers the whole sequence of frames, including the final quiet time.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n=1, sclk=1, busy=0 and sample_valid=0.
- R2: sclk idles high and changes only while cs_n=0. The first falling edge comes DIV system cycles after cs_n falls. Every later sclk level, and the gap from the last sclk rise to cs_n rising, also lasts DIV cycles.
- R3: A conversion frame (cmd_op=2'b00) has exactly NBITS sclk falling edges while cs_n=0. cs_n therefore stays low for (2*NBITS+1)*DIV cycles.
- R4: sdata is sampled at each sclk falling edge, most significant bit first. The word appears on sample in the cycle cs_n rises at the end of a conversion frame, together with a sample_valid pulse that lasts one cycle.
- R5: A sleep frame (cmd_op=2'b01) has PD_FALLS sclk falling edges, where PD_FALLS is between 3 and 9. It raises no sample_valid, and afterwards the converter is recorded as asleep.
- R6: A wake frame (cmd_op=2'b10) has NBITS falling edges. Its data is dropped (no sample_valid), and afterwards the converter is recorded as awake.
- R7: A conversion command given while the converter is recorded as asleep runs a wake frame and then a conversion frame. Exactly one sample_valid results, at the end of the second frame.
- R8: Reset records the converter as asleep, so the first conversion after reset takes two frames.
- R9: Once cs_n rises, it stays high for at least QUIET cycles before it falls again. Between a wake frame and the conversion frame that follows it, cs_n stays high for exactly QUIET cycles.
- R10: busy rises in the cycle after a command is accepted. It stays high through every frame and the quiet time after the last one, for a total of the sum over the frames of (2*falls+1)*DIV+QUIET cycles. cs_n and sclk are high whenever busy is low.
- R11: A command given while busy is high is ignored and produces no extra frame.
- R12: cmd_op=2'b11 is reserved. It starts no frame and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 2 | 00 convert, 01 sleep, 10 wake, 11 reserved |
| busy | output | 1 | A frame or quiet time is in progress |
| sample | output | NBITS | Last converted word |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| cs_n | output | 1 | Chip-select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |

## Verification
The bench builds the controller with DIV=3, QUIET=5, PD_FALLS=3 and NBITS=16. With these values a full frame takes about a hundred system cycles, so dozens of command sequences fit in one run. Every mode transition can be driven from every recorded mode: sleep from asleep and from awake, wake while already awake, and conversion from either mode. A sweep of computed data words checks the bit order of the capture. Frame lengths, clock half-periods, quiet gaps and busy spans are all recomputed in the bench from these parameters.

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DIV      = 3,
  parameter int QUIET    = 8,
  parameter int PD_FALLS = 3,
  parameter int NBITS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             busy,
  output logic [NBITS-1:0] sample,
  output logic             sample_valid,
  output logic             cs_n,
  output logic             sclk,
  input  logic             sdata
);

  localparam int DCW = $clog2(DIV) + 1;
  localparam int QCW = $clog2(QUIET + 1) + 1;
  localparam int FCW = $clog2(NBITS + 1) + 1;
  localparam logic [DCW-1:0] DIV_LAST   = DCW'(DIV - 1);
  localparam logic [QCW-1:0] QUIET_LAST = QCW'(QUIET - 1);
  localparam logic [FCW-1:0] FULL_GOAL  = FCW'(NBITS);
  localparam logic [FCW-1:0] PD_GOAL    = FCW'(PD_FALLS);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_QUIET} state_t;
  typedef enum logic [1:0] {K_CONV, K_SLEEP, K_WAKE} kind_t;

  state_t           state;
  kind_t            kind;
  logic             pend_conv;
  logic             asleep;
  logic [DCW-1:0]   div_cnt;
  logic [QCW-1:0]   qcnt;
  logic [FCW-1:0]   falls;
  logic [NBITS-1:0] shreg;

  wire             tick      = (div_cnt == DIV_LAST);
  wire [FCW-1:0]   fall_goal = (kind == K_SLEEP) ? PD_GOAL : FULL_GOAL;
  wire             accept    = (state == S_IDLE) && cmd_valid && (cmd_op != 2'b11);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      kind         <= K_CONV;
      pend_conv    <= 1'b0;
      asleep       <= 1'b1;
      div_cnt      <= '0;
      qcnt         <= '0;
      falls        <= '0;
      shreg        <= '0;
      sample       <= '0;
      sample_valid <= 1'b0;
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
    end else begin
      sample_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            pend_conv <= 1'b0;
            if (cmd_op == 2'b01) kind <= K_SLEEP;
            else if (cmd_op == 2'b10) kind <= K_WAKE;
            else if (asleep) begin
              kind      <= K_WAKE;
              pend_conv <= 1'b1;
            end else kind <= K_CONV;
            state   <= S_FRAME;
            cs_n    <= 1'b0;
            sclk    <= 1'b1;
            div_cnt <= '0;
            falls   <= '0;
          end
        end
        S_FRAME: begin
          if (!tick) div_cnt <= div_cnt + 1'b1;
          else begin
            div_cnt <= '0;
            if (sclk && falls < fall_goal) begin
              sclk  <= 1'b0;
              falls <= falls + 1'b1;
              shreg <= {shreg[NBITS-2:0], sdata};
            end else if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              cs_n  <= 1'b1;
              state <= S_QUIET;
              qcnt  <= '0;
              case (kind)
                K_CONV: begin
                  sample       <= shreg;
                  sample_valid <= 1'b1;
                end
                K_SLEEP: asleep <= 1'b1;
                default: asleep <= 1'b0;
              endcase
            end
          end
        end
        default: begin
          if (qcnt != QUIET_LAST) qcnt <= qcnt + 1'b1;
          else if (pend_conv) begin
            pend_conv <= 1'b0;
            kind      <= K_CONV;
            state     <= S_FRAME;
            cs_n      <= 1'b0;
            sclk      <= 1'b1;
            div_cnt   <= '0;
            falls     <= '0;
          end else state <= S_IDLE;
        end
      endcase
    end
  end

  logic [QCW-1:0] chk_gap;
  logic [FCW-1:0] chk_falls;
  logic           sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_gap   <= QCW'(QUIET);
      chk_falls <= '0;
      sclk_q    <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (!cs_n) chk_gap <= '0;
      else if (chk_gap != QCW'(QUIET)) chk_gap <= chk_gap + 1'b1;
      if ($fell(cs_n)) chk_falls <= '0;
      else if (sclk_q && !sclk) chk_falls <= chk_falls + 1'b1;
    end
  end

  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && sclk));
  p_sclk_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  p_valid_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $rose(cs_n));
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (chk_falls == FULL_GOAL || chk_falls == PD_GOAL));
  p_sleep_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && chk_falls != FULL_GOAL) |-> (chk_falls > 2 && chk_falls < 10));
  p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (chk_gap == QCW'(QUIET)));

endmodule

// File: tb/tb_adc_frame_ctrl.sv
module tb_adc_frame_ctrl;
  localparam int DIV = 3, QUIET = 5, PDF = 3, NB = 16;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, sdata = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic busy, sample_valid, cs_n, sclk;
  logic [NB-1:0] sample;

  adc_frame_ctrl #(.DIV(DIV), .QUIET(QUIET), .PD_FALLS(PDF), .NBITS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
    .sample(sample), .sample_valid(sample_valid), .cs_n(cs_n), .sclk(sclk), .sdata(sdata));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [NB-1:0] word = '0;
  int bi = NB - 1;

  always @(negedge cs_n or negedge sclk) begin
    if (!cs_n) begin
      if (sclk) bi = NB - 1;
      else if (bi > 0) bi = bi - 1;
      sdata = word[bi];
    end
  end

  int fr_falls[16], fr_low[16], fr_gap[16], fr_bad[16];
  int nf = 0, nvalid = 0, run = 0, lowcnt = 0, highcnt = 1000, fcnt = 0, bad = 0;
  logic [NB-1:0] last_sample = '0;
  logic p_cs = 1'b1, p_sclk = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_valid) begin
        nvalid = nvalid + 1;
        last_sample = sample;
      end
      if (p_cs && !cs_n) begin
        if (nf < 16) fr_gap[nf] = highcnt;
        run = 1; lowcnt = 1; fcnt = 0; bad = 0;
      end else if (!cs_n) begin
        lowcnt = lowcnt + 1;
        if (sclk != p_sclk) begin
          if (run != DIV) bad = bad + 1;
          if (!sclk) fcnt = fcnt + 1;
          run = 1;
        end else run = run + 1;
      end else if (!p_cs && cs_n) begin
        if (run != DIV) bad = bad + 1;
        if (nf < 16) begin
          fr_falls[nf] = fcnt; fr_low[nf] = lowcnt; fr_bad[nf] = bad;
        end
        nf = nf + 1;
        highcnt = 1;
      end else highcnt = highcnt + 1;
      if (cs_n && !sclk) bad = bad + 1;
      p_cs = cs_n; p_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flen(input int f);
    return (2 * f + 1) * DIV;
  endfunction

  task automatic do_cmd(input logic [1:0] op, input int nexp, input int f0, input int f1,
                        input int expv, input logic [NB-1:0] w, input bit poke, input string req);
    int bl, expbl;
    nf = 0; nvalid = 0; word = w;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
    bl = 0;
    while (busy) begin
      bl++;
      if (poke && bl == 10) begin cmd_valid = 1'b1; cmd_op = 2'b01; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && cs_n && sclk, {req, " R10 idle pins"}, {busy, cs_n, sclk}, 3'b011);
    expbl = 0;
    if (nexp > 0) expbl += flen(f0) + QUIET;
    if (nexp > 1) expbl += flen(f1) + QUIET;
    chk(bl == expbl, {req, " R10 busy span"}, bl, expbl);
    chk(nf == nexp, {req, " R11 frame count"}, nf, nexp);
    for (int k = 0; k < nexp && k < nf; k++) begin
      int ef = (k == 0) ? f0 : f1;
      chk(fr_falls[k] == ef, {req, " R3 falls"}, fr_falls[k], ef);
      chk(fr_low[k] == flen(ef), {req, " R2 cs low length"}, fr_low[k], flen(ef));
      chk(fr_bad[k] == 0, {req, " R2 half periods"}, fr_bad[k], 0);
      chk(fr_gap[k] >= QUIET, {req, " R9 quiet min"}, fr_gap[k], QUIET);
      if (k == 1) chk(fr_gap[k] == QUIET, {req, " R9 quiet exact"}, fr_gap[k], QUIET);
    end
    chk(nvalid == expv, {req, " R4 valid count"}, nvalid, expv);
    if (expv > 0) chk(last_sample == w, {req, " R4 sample"}, last_sample, w);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n && sclk && !busy && !sample_valid, "R1 reset pins", {cs_n, sclk, busy, sample_valid}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !busy && !sample_valid, "R1 after reset", {cs_n, sclk, busy, sample_valid}, 4'b1100);
    do_cmd(2'b00, 2, NB, NB, 1, 16'h8001, 1'b0, "R8 first convert");
    for (int i = 0; i < 24; i++) begin
      logic [NB-1:0] w = NB'((i * 16'h1357) ^ (16'hA5C3 >> (i % 16)) ^ (i == 5 ? 16'hFFFF : 16'h0));
      if (i == 0) w = '0;
      if (i == 1) w = '1;
      do_cmd(2'b00, 1, NB, 0, 1, w, 1'b0, "R3 R4 convert sweep");
    end
    do_cmd(2'b01, 1, PDF, 0, 0, 16'h1234, 1'b0, "R5 sleep from awake");
    do_cmd(2'b01, 1, PDF, 0, 0, 16'h4321, 1'b0, "R5 sleep from asleep");
    do_cmd(2'b00, 2, NB, NB, 1, 16'h3C5A, 1'b0, "R7 convert while asleep");
    do_cmd(2'b10, 1, NB, 0, 0, 16'h7777, 1'b0, "R6 wake while awake");
    do_cmd(2'b00, 1, NB, 0, 1, 16'hC001, 1'b0, "R6 convert after wake");
    do_cmd(2'b01, 1, PDF, 0, 0, 16'h0F0F, 1'b0, "R5 sleep again");
    do_cmd(2'b10, 1, NB, 0, 0, 16'hDEAD, 1'b0, "R6 wake from asleep");
    do_cmd(2'b00, 1, NB, 0, 1, 16'hBEEF, 1'b0, "R6 convert after explicit wake");
    do_cmd(2'b11, 0, 0, 0, 0, 16'h1111, 1'b0, "R12 reserved op");
    do_cmd(2'b00, 1, NB, 0, 1, 16'h2468, 1'b1, "R11 command while busy");
    do_cmd(2'b01, 1, PDF, 0, 0, 16'h0000, 1'b1, "R11 sleep with poke");
    do_cmd(2'b00, 2, NB, NB, 1, 16'h9ABC, 1'b0, "R7 convert after poke sleep");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule